// File: doc/BRIEF.md
# Parallel ADC Host Bus Sequencer

This block is a synchronous controller that runs a parallel-bus successive-approximation ADC from logic. A request arrives on a valid/ready handshake. It carries a multiplexer address and a flag that keeps the channel already selected. The sequencer opens a chip-select frame and pulses the write strobe to start a conversion. In address mode it drives the address on the shared data bus during the strobe. In keep mode it leaves the bus undriven. It then waits for the converter's active-low interrupt, pulses the read strobe and captures the result.

Every bus timing limit is a parameter in nanoseconds. Each one is turned into a clock-cycle count by rounding up, using the clock period parameter. These limits are the strobe width, the setup and hold around the rising write edge, the interrupt clear time, the interrupt-to-read spacing, the read access time and the bus release time. The interrupt passes through a two-stage synchronizer. If the interrupt never comes within the timeout, a one-cycle error pulse is raised and the sequencer goes back to idle. Each result is presented with a one-cycle valid pulse.

Top module: `adc_bus_seq`

## Requirements
- R1: While reset is held, and whenever the sequencer is idle with `req_ready` high, `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are high and `bus_oe` is low.
- R2: In address mode (`req_reuse`=0), `adc_wr_n` stays low for max(ceil(150/P), ceil(100/P)) cycles, where P is the clock period in ns (8 cycles at 20 ns). `bus_oe` is high from the cycle WR falls, and `bus_dout` carries `req_chan` zero-extended in its low bits.
- R3: After WR rises in address mode, `bus_oe` stays high with `bus_dout` unchanged for ceil(50/P) cycles (3), and then drops.
- R4: In keep mode (`req_reuse`=1), the write strobe has the same width, but `bus_oe` never rises during the transaction.
- R5: `adc_wr_n` and `adc_rd_n` are never low at the same time, and `bus_oe` is never high while `adc_rd_n` is low.
- R6: An interrupt seen earlier than ceil(400/P) cycles (20) after WR falls is not acted on. An interrupt held low from that early point leads to RD falling ceil(400/P)+ceil(600/P)+1 cycles after WR falls.
- R7: RD falls only after `adc_intr_n` has been low for at least ceil(600/P) cycles (30). With the synchronizer, this is ceil(600/P)+3 cycles after the interrupt falls.
- R8: RD stays low for ceil(225/P) cycles (12). `smp_data` is the value on `bus_din` at the end of that window. `smp_valid` is a single-cycle pulse in the cycle RD rises.
- R9: If no interrupt arrives within ceil(60000/P) cycles (3000) of WR falling, `smp_err` pulses once. No read strobe and no valid pulse follow, and the sequencer returns to idle.
- R10: `req_ready` returns ceil(225/P) cycles (12) after RD rises, and the bus is not driven during that time.
- R11: `adc_cs_n` is low whenever WR or RD is low.
- R12: Changes on `req_valid`, `req_chan` and `req_reuse` while `req_ready` is low have no effect on the running transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_chan | input | ADDR_W | Multiplexer address written in address mode |
| req_reuse | input | 1 | 1: start with the previous channel selection |
| smp_valid | output | 1 | One-cycle pulse, result valid |
| smp_data | output | DATA_W | Captured conversion result |
| smp_err | output | 1 | One-cycle pulse, interrupt timeout |
| bus_din | input | DATA_W | Data bus value as read from the pads |
| bus_dout | output | DATA_W | Data bus value to drive |
| bus_oe | output | 1 | Data bus output enable |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_wr_n | output | 1 | Write / start strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_intr_n | input | 1 | Conversion done, active low, asynchronous |

## Verification
Two things can fall into the same phase of a transaction: the interrupt and the write strobe. This happens when a converter leaves its interrupt low from an earlier conversion. The bench provokes it by pulling the interrupt low two cycles after WR falls. It judges the outcome by the exact distance from the WR fall to the RD fall, which must reflect both the clear window and the spacing window. A second overlap comes from a request held high with a changed channel and mode while the sequencer is still busy. The bench judges it by the address latched at the write edge and by the bus enable staying on the original mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRLO,
    ST_HOLD,
    ST_WAIT,
    ST_GAP,
    ST_RDLO,
    ST_REL
  } seq_state_e;

  // Round a duration in ns up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int dur_ns, input int per_ns);
    int c;
    c = (dur_ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
// Phase timer: loaded with N-1 on entry, phase ends when it reads zero.
module adc_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_elapsed.sv
// Saturating cycle counter measured from the start strobe.
module adc_seq_elapsed #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (run && (cnt_q != '1));
    cnt_d  = clr ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/adc_seq_capture.sv
// Holds the address to drive and the captured result with its valid pulse.
module adc_seq_capture #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              smp_ld,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] addr_bus,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_valid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_ld) addr_q <= addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (smp_ld) data_q <= bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= smp_ld;
  end

  assign addr_bus  = DATA_W'(addr_q);
  assign smp_data  = data_q;
  assign smp_valid = valid_q;

endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 4,
  parameter int T_WR_LOW_NS   = 150,
  parameter int T_SETUP_NS    = 100,
  parameter int T_HOLD_NS     = 50,
  parameter int T_INTR_CLR_NS = 400,
  parameter int T_INTR_RD_NS  = 600,
  parameter int T_ACCESS_NS   = 225,
  parameter int T_RELEASE_NS  = 225,
  parameter int T_TIMEOUT_NS  = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  input  logic              req_reuse,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_err,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              adc_cs_n,
  output logic              adc_wr_n,
  output logic              adc_rd_n,
  input  logic              adc_intr_n
);

  // WR low must cover both the strobe width and the data setup time.
  localparam int WRL_CYC  = imax(ns_to_cyc(T_WR_LOW_NS, CLK_PERIOD_NS),
                                 ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS));
  localparam int HOLD_CYC = ns_to_cyc(T_HOLD_NS, CLK_PERIOD_NS);
  localparam int CLR_CYC  = ns_to_cyc(T_INTR_CLR_NS, CLK_PERIOD_NS);
  localparam int GAP_CYC  = ns_to_cyc(T_INTR_RD_NS, CLK_PERIOD_NS);
  localparam int ACC_CYC  = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int REL_CYC  = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int TO_CYC   = ns_to_cyc(T_TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int PH_MAX   = imax(imax(WRL_CYC, HOLD_CYC),
                                 imax(GAP_CYC, imax(ACC_CYC, REL_CYC)));
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int EL_W     = $clog2(imax(TO_CYC, CLR_CYC) + 2);

  logic rst_int_n;
  logic intr_s_n;

  seq_state_e state_q, state_d;
  logic       reuse_q;
  logic       accept, capture, err_d, drive_d;
  logic       t_load, t_zero;
  logic [PH_W-1:0] t_val;
  logic       el_run;
  logic [EL_W-1:0] el_cnt;

  logic wr_n_q, rd_n_q, cs_n_q, oe_q, err_q;

  // Reset: asserted asynchronously, released on a clock edge.
  adc_seq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  adc_seq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_intr_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (adc_intr_n),
    .q     (intr_s_n)
  );

  adc_seq_timer #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  assign el_run = (state_q == ST_WRLO) || (state_q == ST_HOLD) || (state_q == ST_WAIT);

  adc_seq_elapsed #(.W(EL_W)) u_elapsed (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (accept),
    .run   (el_run),
    .count (el_cnt)
  );

  adc_seq_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .addr_ld   (accept),
    .addr_in   (req_chan),
    .smp_ld    (capture),
    .bus_in    (bus_din),
    .addr_bus  (bus_dout),
    .smp_data  (smp_data),
    .smp_valid (smp_valid)
  );

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    capture = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_WRLO;
          t_load  = 1'b1;
          t_val   = PH_W'(WRL_CYC - 1);
        end
      end
      ST_WRLO: begin
        if (t_zero) begin
          if (reuse_q) begin
            state_d = ST_WAIT;
          end else begin
            state_d = ST_HOLD;
            t_load  = 1'b1;
            t_val   = PH_W'(HOLD_CYC - 1);
          end
        end
      end
      ST_HOLD: begin
        if (t_zero) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (el_cnt >= EL_W'(TO_CYC)) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if ((el_cnt >= EL_W'(CLR_CYC)) && !intr_s_n) begin
          state_d = ST_GAP;
          t_load  = 1'b1;
          t_val   = PH_W'(GAP_CYC - 1);
        end
      end
      ST_GAP: begin
        if (t_zero) begin
          state_d = ST_RDLO;
          t_load  = 1'b1;
          t_val   = PH_W'(ACC_CYC - 1);
        end
      end
      ST_RDLO: begin
        if (t_zero) begin
          capture = 1'b1;
          state_d = ST_REL;
          t_load  = 1'b1;
          t_val   = PH_W'(REL_CYC - 1);
        end
      end
      ST_REL: begin
        if (t_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    drive_d = (state_d == ST_HOLD) ||
              ((state_d == ST_WRLO) && (accept ? !req_reuse : !reuse_q));
  end

  // State and registered pin drivers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      wr_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
      cs_n_q  <= 1'b1;
      oe_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_n_q  <= (state_d != ST_WRLO);
      rd_n_q  <= (state_d != ST_RDLO);
      cs_n_q  <= (state_d == ST_IDLE) || (state_d == ST_REL);
      oe_q    <= drive_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  reuse_q <= 1'b0;
    else if (accept) reuse_q <= req_reuse;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign adc_wr_n  = wr_n_q;
  assign adc_rd_n  = rd_n_q;
  assign adc_cs_n  = cs_n_q;
  assign bus_oe    = oe_q;
  assign smp_err   = err_q;

endmodule

// File: rtl/adc_bus_seq_chk.sv
module adc_bus_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int DATA_W        = 8,
  parameter int T_WR_LOW_NS   = 150,
  parameter int T_SETUP_NS    = 100,
  parameter int T_INTR_RD_NS  = 600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_wr_n,
  input logic              adc_rd_n,
  input logic              adc_cs_n,
  input logic              adc_intr_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_dout,
  input logic              smp_valid,
  input logic              smp_err,
  input logic              req_ready
);

  localparam int WRL_CYC = imax(ns_to_cyc(T_WR_LOW_NS, CLK_PERIOD_NS),
                                ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS));
  localparam int GAP_CYC = ns_to_cyc(T_INTR_RD_NS, CLK_PERIOD_NS);

  logic [15:0] wr_run, intr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run   <= '0;
      intr_run <= '0;
    end else begin
      wr_run   <= adc_wr_n ? 16'd0 : ((wr_run == 16'hFFFF) ? wr_run : wr_run + 16'd1);
      intr_run <= adc_intr_n ? 16'd0 : ((intr_run == 16'hFFFF) ? intr_run : intr_run + 16'd1);
    end
  end

  assert_idle_cs_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> adc_cs_n);

  assert_wr_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_wr_n) |-> (wr_run >= 16'(WRL_CYC)));

  assert_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_wr_n && bus_oe) |=> (bus_oe && $stable(bus_dout)));

  assert_wr_rd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_wr_n && !adc_rd_n));

  assert_no_drive_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !bus_oe);

  assert_intr_to_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> (intr_run >= 16'(GAP_CYC)));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  assert_err_excl_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_err && smp_valid));

  assert_cs_frames_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_wr_n || !adc_rd_n) |-> !adc_cs_n);

endmodule

bind adc_bus_seq adc_bus_seq_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .DATA_W        (DATA_W),
  .T_WR_LOW_NS   (T_WR_LOW_NS),
  .T_SETUP_NS    (T_SETUP_NS),
  .T_INTR_RD_NS  (T_INTR_RD_NS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adc_wr_n   (adc_wr_n),
  .adc_rd_n   (adc_rd_n),
  .adc_cs_n   (adc_cs_n),
  .adc_intr_n (adc_intr_n),
  .bus_oe     (bus_oe),
  .bus_dout   (bus_dout),
  .smp_valid  (smp_valid),
  .smp_err    (smp_err),
  .req_ready  (req_ready)
);

// File: tb/adc_bus_seq_tb.sv
`timescale 1ns/1ps
module adc_bus_seq_tb;

  localparam int CLK_NS = 20;
  localparam int DW = 8;
  localparam int AW = 4;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  localparam int E_WRL  = (cdiv(150, CLK_NS) > cdiv(100, CLK_NS)) ? cdiv(150, CLK_NS) : cdiv(100, CLK_NS);
  localparam int E_HOLD = cdiv(50, CLK_NS);
  localparam int E_CLR  = cdiv(400, CLK_NS);
  localparam int E_GAP  = cdiv(600, CLK_NS);
  localparam int E_ACC  = cdiv(225, CLK_NS);
  localparam int E_REL  = cdiv(225, CLK_NS);
  localparam int E_TO   = cdiv(60000, CLK_NS);
  localparam int WDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_reuse;
  logic [AW-1:0] req_chan;
  logic smp_valid, smp_err, bus_oe;
  logic [DW-1:0] smp_data, bus_din, bus_dout;
  logic adc_cs_n, adc_wr_n, adc_rd_n, adc_intr_n;

  always #(CLK_NS/2) clk = ~clk;

  adc_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_reuse(req_reuse),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_err(smp_err),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
    .adc_intr_n(adc_intr_n)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Converter model, evaluated on the falling clock edge.
  int  cyc = 0;
  int  mode = 0;          // 0 normal, 1 early interrupt, 2 no interrupt
  int  conv_dly = 40;
  logic [DW-1:0] sample = '0;
  logic [DW-1:0] latched_addr = '0;
  logic p_wr = 1, p_rd = 1, p_rdy = 1;
  int  wr_fall, wr_len, hold_len, oe_cnt, intr_at, intr_fall;
  int  rd_fall, rd_rise, rd_len, rd_cnt, data_at, rdy_rise;
  int  valid_cnt, valid_cyc, err_cnt, err_cyc, viol_excl, viol_cs;
  logic [DW-1:0] got_data;
  bit  after_wr, txn_done;

  task automatic model_clear();
    wr_fall = -1; wr_len = 0; hold_len = 0; oe_cnt = 0; intr_at = -1;
    intr_fall = -1; rd_fall = -1; rd_rise = -1; rd_len = 0; rd_cnt = 0;
    data_at = -1; rdy_rise = -1; valid_cnt = 0; valid_cyc = -1;
    err_cnt = 0; err_cyc = -1; viol_excl = 0; viol_cs = 0; got_data = '0;
    after_wr = 0; txn_done = 0;
  endtask

  initial begin
    adc_intr_n = 1'b1;
    bus_din = '0;
    model_clear();
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!adc_wr_n && !adc_rd_n) viol_excl++;
      if (!adc_rd_n && bus_oe)    viol_excl++;
      if ((!adc_wr_n || !adc_rd_n) && adc_cs_n) viol_cs++;
      if (bus_oe) oe_cnt++;
      if (p_wr && !adc_wr_n) begin wr_fall = cyc; after_wr = 0; end
      if (!adc_wr_n) wr_len++;
      if (!p_wr && adc_wr_n) begin
        if (bus_oe) latched_addr = bus_dout;
        after_wr = 1;
        if (mode == 0) intr_at = cyc + conv_dly;
      end
      if (after_wr && adc_wr_n && bus_oe) hold_len++;
      if (mode == 1 && wr_fall >= 0 && cyc == wr_fall + 2) begin
        adc_intr_n = 1'b0; intr_fall = cyc;
      end
      if (cyc == intr_at) begin adc_intr_n = 1'b0; intr_fall = cyc; end
      if (p_rd && !adc_rd_n) begin
        rd_fall = cyc; rd_cnt++; bus_din = 8'hA5; data_at = cyc + 8;
      end
      if (!adc_rd_n) rd_len++;
      if (cyc == data_at) begin bus_din = sample; adc_intr_n = 1'b1; end
      if (!p_rd && adc_rd_n) begin rd_rise = cyc; bus_din = '0; end
      if (smp_valid) begin valid_cnt++; valid_cyc = cyc; got_data = smp_data; txn_done = 1; end
      if (smp_err) begin err_cnt++; err_cyc = cyc; txn_done = 1; end
      if (!p_rdy && req_ready && rdy_rise < 0) rdy_rise = cyc;
    end
    p_wr = adc_wr_n; p_rd = adc_rd_n; p_rdy = req_ready;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > WDOG) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WDOG);
      finish_run();
    end
  end

  function automatic logic [DW-1:0] smp_of(input int ch, input bit ru);
    logic [DW-1:0] v;
    v = DW'(ch * 37 + (ru ? 91 : 0) + 12);
    if (v == 8'hA5) v = 8'h5A;
    return v;
  endfunction

  // m: 0 normal, 1 early interrupt, 2 no interrupt, 3 request churn while busy
  task automatic run_txn(input int ch, input bit ru, input int m);
    logic [DW-1:0] prev_addr;
    while (!req_ready) step();
    prev_addr = latched_addr;
    model_clear();
    mode = (m == 3) ? 0 : m;
    conv_dly = 40 + ch * 5;
    sample = smp_of(ch, ru);
    req_chan = AW'(ch); req_reuse = ru; req_valid = 1'b1;
    step();
    if (m == 3) begin req_chan = ~AW'(ch); req_reuse = !ru; end
    else req_valid = 1'b0;
    while (!txn_done) step();
    while (!req_ready) step();
    req_valid = 1'b0;
    step(); step();

    chk(wr_len == E_WRL, "R2", "WR low cycles", wr_len, E_WRL);
    if (!ru) begin
      chk(latched_addr == DW'(ch), "R2", "address at WR rise", int'(latched_addr), ch);
      chk(hold_len == E_HOLD, "R3", "hold cycles", hold_len, E_HOLD);
    end else begin
      chk(oe_cnt == 0, "R4", "bus drive in keep mode", oe_cnt, 0);
      chk(latched_addr == prev_addr, "R4", "selection kept", int'(latched_addr), int'(prev_addr));
    end
    chk(viol_excl == 0, "R5", "strobe/drive overlap", viol_excl, 0);
    chk(viol_cs == 0, "R11", "strobe outside CS", viol_cs, 0);
    if (m == 2) begin
      chk((err_cyc - wr_fall) >= E_TO && (err_cyc - wr_fall) <= E_TO + 3,
          "R9", "timeout distance", err_cyc - wr_fall, E_TO + 1);
      chk(err_cnt == 1, "R9", "error pulses", err_cnt, 1);
      chk(rd_cnt == 0 && valid_cnt == 0, "R9", "read after timeout", rd_cnt + valid_cnt, 0);
    end else begin
      if (m == 1)
        chk((rd_fall - wr_fall) >= E_CLR + E_GAP && (rd_fall - wr_fall) <= E_CLR + E_GAP + 3,
            "R6", "WR fall to RD fall with early interrupt", rd_fall - wr_fall, E_CLR + E_GAP + 1);
      else
        chk((rd_fall - intr_fall) >= E_GAP + 2 && (rd_fall - intr_fall) <= E_GAP + 4,
            "R7", "interrupt to RD fall", rd_fall - intr_fall, E_GAP + 3);
      chk(rd_len == E_ACC, "R8", "RD low cycles", rd_len, E_ACC);
      chk(got_data == sample, "R8", "captured sample", int'(got_data), int'(sample));
      chk(valid_cnt == 1 && valid_cyc == rd_rise, "R8", "valid pulse at RD rise",
          valid_cyc - rd_rise + 100 * (valid_cnt - 1), 0);
      chk((rdy_rise - rd_rise) == E_REL, "R10", "RD rise to ready", rdy_rise - rd_rise, E_REL);
      chk(err_cnt == 0, "R9", "no error on normal conversion", err_cnt, 0);
    end
    if (m == 3)
      chk(oe_cnt == E_WRL + E_HOLD, "R12", "drive cycles kept original mode", oe_cnt, E_WRL + E_HOLD);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_chan = '0; req_reuse = 1'b0;
    repeat (4) step();
    chk(adc_cs_n && adc_wr_n && adc_rd_n && !bus_oe, "R1", "pins in reset",
        {adc_cs_n, adc_wr_n, adc_rd_n, bus_oe}, 4'b1110);
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    repeat (4) step();
    chk(adc_cs_n && adc_wr_n && adc_rd_n && !bus_oe && req_ready, "R1", "idle after reset",
        {adc_cs_n, adc_wr_n, adc_rd_n, bus_oe, req_ready}, 5'b11101);

    for (int ch = 0; ch < (1 << AW); ch++) run_txn(ch, 1'b0, 0);
    for (int ch = 0; ch < (1 << AW); ch++) run_txn(ch, 1'b1, 0);
    run_txn(5, 1'b0, 1);
    run_txn(9, 1'b1, 1);
    run_txn(6, 1'b0, 3);
    run_txn(3, 1'b0, 2);
    run_txn(10, 1'b0, 0);
    chk(adc_cs_n && !bus_oe && req_ready, "R1", "idle at end",
        {adc_cs_n, bus_oe, req_ready}, 3'b101);
    finish_run();
  end

endmodule